// File: doc/BRIEF.md
# Receive Stale-Data Timeout Detector

This block tells a serial receiver's host that bytes have been sitting unread in the receive queue for too long. It measures idle time in whole character times. The length of one character time follows the configured frame: a start bit, 5 to 8 data bits, an optional parity bit, and one or two stop bits. Each bit lasts a fixed number of oversampling ticks, 16 by default. When the queue holds data and no character has arrived, no read has happened and no start bit has been seen for four whole character times, the timeout flag goes high. The flag stays high until it is cleared.

A single idle timer restarts whenever a character is received, the queue is read or a new start bit is detected. The flag only reaches the output while both the queue and the timeout indication are enabled and the queue is not empty. Clearing either enable, or draining the queue, drops the flag in the same cycle. The receiver, the queue and the interrupt logic sit outside this block. They supply the tick, the frame configuration, the enables and the event pulses.

Top module: `rx_stale_timeout`

## Requirements
- R1: With both enables high and `fifo_nonempty` high, `timeout` stays low until exactly IDLE_CHARS (4) character times of baud ticks have followed the last restart event. It goes high on the cycle after the tick that completes the last of them.
- R2: One character time is OVERSAMPLE (16) baud ticks multiplied by the frame bits. Frame bits are 1 start bit, plus 5 + `data_bits` data bits (`data_bits` code 0..3 selects 5..8), plus 1 if `parity_en`, plus 2 if `two_stop` else 1, giving 7 to 12 bits.
- R3: A `char_rcvd` pulse restarts the idle timer, so a timeout needs a further full IDLE_CHARS character times.
- R4: A `fifo_read` pulse drops an asserted `timeout` on the next cycle and restarts the idle timer.
- R5: A `start_seen` pulse drops an asserted `timeout` on the next cycle and restarts the idle timer.
- R6: While `fifo_nonempty` is low, `timeout` is low in the same cycle. The elapsed idle time is kept, so the flag returns as soon as the queue is non-empty again.
- R7: While `fifo_en` or `tmo_en` is low, `timeout` is low in the same cycle.
- R8: Once the limit has been reached, further ticks keep `timeout` high until a restart event occurs.
- R9: Cycles without `baud_tick` do not advance the idle timer.
- R10: After reset, `timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle oversampling tick |
| fifo_en | input | 1 | Receive queue enabled |
| tmo_en | input | 1 | Timeout indication enabled |
| data_bits | input | 2 | Data length code, 0..3 selects 5..8 bits |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| fifo_nonempty | input | 1 | Receive queue holds at least one character |
| char_rcvd | input | 1 | Pulse: a character entered the queue |
| fifo_read | input | 1 | Pulse: one character was read from the queue |
| start_seen | input | 1 | Pulse: a new start bit was detected |
| timeout | output | 1 | Stale-data timeout flag |

## Verification
The bench places the limit to the exact tick for several frame shapes, shortest and longest included. A timer that used the wrong frame length, or that was off by one, would raise the flag one tick early or late, and the adjacent pair of checks reports it. Each restart source is fired both before and after the flag is set. A design that ignored start bits, or that cleared the flag without restarting the count, would show the flag again too soon or keep it high. Gating checks drop the queue flag and each enable while the flag is up, then restore them, which catches a design that gates late or forgets the elapsed time. A long stretch without ticks confirms that only ticks advance time.

// File: rtl/rx_tmo_pkg.sv
package rx_tmo_pkg;

   typedef enum logic [1:0] {
      DLEN_5 = 2'd0,
      DLEN_6 = 2'd1,
      DLEN_7 = 2'd2,
      DLEN_8 = 2'd3
   } dlen_e;

   localparam int unsigned MIN_DATA   = 5;
   localparam int unsigned MAX_FRAME  = 12;
   localparam int unsigned MIN_FRAME  = 7;
   localparam int unsigned FRAME_W    = $clog2(MAX_FRAME + 1);

   typedef logic [FRAME_W-1:0] frame_len_t;

   typedef struct packed {
      dlen_e dlen;
      logic  parity;
      logic  stop2;
   } frame_cfg_t;

endpackage

// File: rtl/rx_tmo_frame_len.sv
module rx_tmo_frame_len
   import rx_tmo_pkg::*;
(
   input  frame_cfg_t cfg_i,
   output frame_len_t bits_o
);

   frame_len_t data_n;
   frame_len_t par_n;
   frame_len_t stop_n;

   always_comb begin
      data_n = frame_len_t'(MIN_DATA) + frame_len_t'(cfg_i.dlen);
      par_n  = cfg_i.parity ? frame_len_t'(1) : frame_len_t'(0);
      stop_n = cfg_i.stop2  ? frame_len_t'(2) : frame_len_t'(1);
      bits_o = frame_len_t'(1) + data_n + par_n + stop_n;
   end

endmodule

// File: rtl/rx_tmo_bit_clk.sv
module rx_tmo_bit_clk #(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic tick_i,
   output logic bit_stb_o
);

   localparam int unsigned CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
   localparam bit IS_POW2 = (OVERSAMPLE & (OVERSAMPLE - 1)) == 0;

   logic [CNT_W-1:0] sub_q;

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("rx_tmo_bit_clk: OVERSAMPLE must be at least 2");
      end

      if (IS_POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sub_q <= '0;
            else if (restart_i) sub_q <= '0;
            else if (tick_i)    sub_q <= sub_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sub_q <= '0;
            else if (restart_i) sub_q <= '0;
            else if (tick_i)    sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
         end
      end
   endgenerate

   assign bit_stb_o = tick_i && !restart_i && (sub_q == LAST);

   assert_no_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !restart_i) |=> $stable(sub_q));

   assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (sub_q == '0));

endmodule

// File: rtl/rx_tmo_char_timer.sv
module rx_tmo_char_timer
   import rx_tmo_pkg::*;
#(
   parameter int unsigned IDLE_CHARS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart_i,
   input  logic       bit_stb_i,
   input  frame_len_t frame_bits_i,
   output logic       stale_o
);

   localparam int unsigned CC_W = $clog2(IDLE_CHARS + 1);
   localparam logic [CC_W-1:0] LIMIT = CC_W'(IDLE_CHARS);

   frame_len_t       bit_q;
   logic [CC_W-1:0]  chr_q;
   logic             char_end;

   generate
      if (IDLE_CHARS < 1) begin : g_bad_idle
         $error("rx_tmo_char_timer: IDLE_CHARS must be at least 1");
      end
   endgenerate

   assign char_end = bit_stb_i && (bit_q >= frame_bits_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= '0;
      else if (restart_i)  bit_q <= '0;
      else if (char_end)   bit_q <= '0;
      else if (bit_stb_i)  bit_q <= bit_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        chr_q <= '0;
      else if (restart_i)                chr_q <= '0;
      else if (char_end && chr_q != LIMIT) chr_q <= chr_q + 1'b1;
   end

   assign stale_o = (chr_q == LIMIT);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chr_q <= LIMIT);

   assert_stale_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stale_o && !restart_i) |=> stale_o);

   assert_stale_only_at_char_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stale_o) |-> $past(char_end));

   assert_bit_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_q < frame_len_t'(MAX_FRAME));

endmodule

// File: rtl/rx_stale_timeout.sv
module rx_stale_timeout
   import rx_tmo_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned IDLE_CHARS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       fifo_en,
   input  logic       tmo_en,
   input  logic [1:0] data_bits,
   input  logic       parity_en,
   input  logic       two_stop,
   input  logic       fifo_nonempty,
   input  logic       char_rcvd,
   input  logic       fifo_read,
   input  logic       start_seen,
   output logic       timeout
);

   frame_cfg_t cfg;
   frame_len_t frame_bits;
   logic       restart;
   logic       bit_stb;
   logic       stale;

   assign cfg.dlen   = dlen_e'(data_bits);
   assign cfg.parity = parity_en;
   assign cfg.stop2  = two_stop;

   assign restart = char_rcvd | fifo_read | start_seen;

   rx_tmo_frame_len u_len (
      .cfg_i  (cfg),
      .bits_o (frame_bits)
   );

   rx_tmo_bit_clk #(.OVERSAMPLE(OVERSAMPLE)) u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .tick_i    (baud_tick),
      .bit_stb_o (bit_stb)
   );

   rx_tmo_char_timer #(.IDLE_CHARS(IDLE_CHARS)) u_ctmr (
      .clk          (clk),
      .rst_n        (rst_n),
      .restart_i    (restart),
      .bit_stb_i    (bit_stb),
      .frame_bits_i (frame_bits),
      .stale_o      (stale)
   );

   assign timeout = stale & fifo_en & tmo_en & fifo_nonempty;

   assert_frame_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_bits >= frame_len_t'(MIN_FRAME)) && (frame_bits <= frame_len_t'(MAX_FRAME)));

   assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_read |=> !timeout);

   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |=> !timeout);

   assert_char_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      char_rcvd |=> !timeout);

endmodule

// File: tb/tb_rx_stale_timeout.sv
`timescale 1ns/1ps
module tb_rx_stale_timeout;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic fifo_en = 1'b1;
   logic tmo_en = 1'b1;
   logic [1:0] data_bits = 2'd3;
   logic parity_en = 1'b0;
   logic two_stop = 1'b0;
   logic fifo_nonempty = 1'b1;
   logic char_rcvd = 1'b0;
   logic fifo_read = 1'b0;
   logic start_seen = 1'b0;
   logic timeout;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   rx_stale_timeout dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_en(fifo_en),
      .tmo_en(tmo_en), .data_bits(data_bits), .parity_en(parity_en),
      .two_stop(two_stop), .fifo_nonempty(fifo_nonempty), .char_rcvd(char_rcvd),
      .fifo_read(fifo_read), .start_seen(start_seen), .timeout(timeout)
   );

   task automatic check(input logic got, input logic exp, input string req);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: timeout=%0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   // n ticks, one per cycle; returns at a negedge after the n-th posedge
   task automatic ticks(input int n);
      if (n > 0) begin
         baud_tick = 1'b1;
         repeat (n) @(negedge clk);
         baud_tick = 1'b0;
      end
   endtask

   task automatic pulse(input int which);
      case (which)
         0: char_rcvd  = 1'b1;
         1: fifo_read  = 1'b1;
         default: start_seen = 1'b1;
      endcase
      @(negedge clk);
      char_rcvd = 1'b0; fifo_read = 1'b0; start_seen = 1'b0;
   endtask

   function automatic int frame_len(input int db, input bit par, input bit st2);
      return 1 + 5 + db + (par ? 1 : 0) + (st2 ? 2 : 1);
   endfunction

   int lim;

   task automatic set_cfg(input int db, input bit par, input bit st2);
      data_bits = db[1:0]; parity_en = par; two_stop = st2;
      lim = 4 * 16 * frame_len(db, par, st2);
   endtask

   // R1/R2: exact threshold after a char_rcvd restart
   task automatic t_threshold(input int db, input bit par, input bit st2);
      set_cfg(db, par, st2);
      pulse(0);
      ticks(lim - 1);
      check(timeout, 1'b0, "R1 one tick before limit");
      ticks(1);
      check(timeout, 1'b1, "R2 at limit for frame");
   endtask

   task automatic t_reset();
      check(timeout, 1'b0, "R10 reset state");
   endtask

   task automatic t_hold();
      ticks(300);
      check(timeout, 1'b1, "R8 held after extra ticks");
      repeat (50) @(negedge clk);
      check(timeout, 1'b1, "R8 held without ticks");
   endtask

   task automatic t_clear(input int which, input string req);
      pulse(which);
      check(timeout, 1'b0, req);
      ticks(lim - 1);
      check(timeout, 1'b0, req);
      ticks(1);
      check(timeout, 1'b1, req);
   endtask

   task automatic t_char_midway();
      pulse(0);
      ticks(lim / 2);
      pulse(0);
      ticks(lim - 1);
      check(timeout, 1'b0, "R3 char restarts count");
      ticks(1);
      check(timeout, 1'b1, "R3 limit after char restart");
   endtask

   task automatic t_empty();
      fifo_nonempty = 1'b0; #1;
      check(timeout, 1'b0, "R6 empty gates same cycle");
      ticks(20);
      check(timeout, 1'b0, "R6 stays low while empty");
      fifo_nonempty = 1'b1; #1;
      check(timeout, 1'b1, "R6 elapsed time kept");
   endtask

   task automatic t_enables();
      fifo_en = 1'b0; #1;
      check(timeout, 1'b0, "R7 fifo_en low");
      fifo_en = 1'b1; tmo_en = 1'b0; #1;
      check(timeout, 1'b0, "R7 tmo_en low");
      tmo_en = 1'b1; #1;
      check(timeout, 1'b1, "R7 restored");
   endtask

   task automatic t_no_tick();
      pulse(2);
      repeat (3000) @(negedge clk);
      check(timeout, 1'b0, "R9 idle cycles do not count");
      ticks(lim - 1);
      check(timeout, 1'b0, "R9 count only ticks");
      ticks(1);
      check(timeout, 1'b1, "R9 limit by ticks");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_threshold(0, 1'b0, 1'b0);   // 7 bits
      t_threshold(3, 1'b1, 1'b1);   // 12 bits
      t_threshold(1, 1'b0, 1'b1);   // 9 bits
      t_threshold(3, 1'b0, 1'b0);   // 10 bits
      t_hold();
      t_clear(1, "R4 read clears and restarts");
      t_clear(2, "R5 start bit clears and restarts");
      t_char_midway();
      t_empty();
      t_enables();
      t_no_tick();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule